// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 40-bit physical address by reading entries from a two-level table tree held in memory. A requester presents the linear address, the base of the top-level table and an enable for 4 MB mappings. The walker then reads one 32-bit entry per level over a simple request/response memory port. It finishes with a one-cycle completion pulse that carries the physical address, or with a one-cycle fault pulse that reports the level and the cause.

Each entry decides how the walk goes on. A clear present bit ends the walk with a fault. At the top level, a set size bit (when 4 MB mappings are enabled) ends the walk early at a 4 MB frame, and a set reserved bit on that path raises a fault. A second-level entry always maps a 4 KB frame. Only one walk runs at a time. The request inputs are captured when the walk is accepted, so they can change while the walk runs.

Top module: `page_walker`

## Requirements
- R1: One cycle after a request is accepted, `mem_req` is high for exactly one cycle, and `mem_addr` = {root[31:12], lin[31:22], 2'b00}.
- R2: When the first entry points to a table, a second one-cycle read is issued at {entry1[31:12], lin[21:12], 2'b00}.
- R3: A 4 KB result completes with `done` high for one cycle and `phys_addr` = {8'h00, entry2[31:12], lin[11:0]}.
- R4: When `req_large_en`=1 and first-entry bit 7 = 1, with bit 0 = 1 and bit 21 = 0, the walk ends after one read with `phys_addr` = {entry1[20:13], entry1[31:22], lin[21:0]}.
- R5: When `req_large_en`=0, first-entry bit 7 is ignored and the walk always continues to the second level.
- R6: Second-level entry bit 7 has no effect on the result.
- R7: An entry with bit 0 = 0 ends the walk with `fault` high for one cycle and `fault_cause`=0 (not present). This check takes priority over the size bit and the reserved bit.
- R8: A present first-level entry taken as a 4 MB mapping with bit 21 = 1 faults with `fault_cause`=1 (reserved bit) and level 1. With `req_large_en`=0, bit 21 is not checked.
- R9: On a fault, `phys_addr` is zero and `fault_level` is 2'd1 for the first level or 2'd2 for the second level. `done` and `fault` are never high together.
- R10: `req_ready` is low from acceptance through the result cycle. A `req_valid` held during that time starts no walk until the walk after the result cycle. A `mem_rvalid` that arrives while idle has no effect.
- R11: After reset, `req_ready`=1, `mem_req`=0, `done`=0, `fault`=0 and `phys_addr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_lin | input | 32 | Linear address |
| req_root | input | 32 | Top-level table base (bits 31:12 used) |
| req_large_en | input | 1 | Allow 4 MB mappings at the first level |
| mem_req | output | 1 | Entry read strobe, one cycle |
| mem_addr | output | 32 | Entry byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Entry read data |
| done | output | 1 | Translation result pulse |
| fault | output | 1 | Fault pulse |
| phys_addr | output | 40 | Physical address, zero after a fault |
| fault_level | output | 2 | Failing level (1 or 2) |
| fault_cause | output | 1 | 0 = not present, 1 = reserved bit |

## Verification
The result pulse of one walk can arrive in the same cycle as a waiting request for the next walk. The bench holds `req_valid` high with a different linear address throughout a walk. It then checks three things: `req_ready` stays low in the result cycle, the result still belongs to the first address, and the second walk starts only after that cycle. A stray `mem_rvalid` is also pulsed while the walker is idle, and the bench confirms that no read and no result follow from it.

// File: rtl/pw_pkg.sv
`timescale 1ns/1ps
package pw_pkg;
  localparam int LA_W   = 32;
  localparam int PA_W   = 40;
  localparam int ENT_W  = 32;
  localparam int OFF_W  = 12;
  localparam int IDX_W  = 10;
  localparam int HI_W   = PA_W - LA_W;
  localparam int BIG_W  = OFF_W + IDX_W;
  localparam int PRESENT_BIT = 0;
  localparam int SIZE_BIT    = 7;
  localparam int RSVD_BIT    = BIG_W - 1;

  typedef enum logic [2:0] {
    S_IDLE, S_RD1, S_WT1, S_RD2, S_WT2, S_RESP
  } walk_state_t;

  typedef enum logic {
    FC_NOT_PRESENT = 1'b0,
    FC_RESERVED    = 1'b1
  } fault_cause_t;

  typedef enum logic [1:0] {
    EK_POINTER, EK_MAPPED, EK_FAULT
  } entry_kind_t;
endpackage

// File: rtl/pw_entry_decode.sv
`timescale 1ns/1ps
module pw_entry_decode
  import pw_pkg::*;
(
  input  logic [ENT_W-1:0] entry,
  input  logic             is_leaf,
  input  logic             large_en,
  input  logic [LA_W-1:0]  lin,
  output entry_kind_t      kind,
  output fault_cause_t     cause,
  output logic [PA_W-1:0]  pa
);
  logic unused_bits;
  assign unused_bits = ^{entry[OFF_W], entry[OFF_W-1:SIZE_BIT+1], entry[SIZE_BIT-1:PRESENT_BIT+1]};

  always_comb begin
    kind  = EK_POINTER;
    cause = FC_NOT_PRESENT;
    pa    = '0;
    if (!entry[PRESENT_BIT]) begin
      kind = EK_FAULT;
    end else if (is_leaf) begin
      kind = EK_MAPPED;
      pa   = {{HI_W{1'b0}}, entry[ENT_W-1:OFF_W], lin[OFF_W-1:0]};
    end else if (large_en && entry[SIZE_BIT]) begin
      if (entry[RSVD_BIT]) begin
        kind  = EK_FAULT;
        cause = FC_RESERVED;
      end else begin
        kind = EK_MAPPED;
        pa   = {entry[RSVD_BIT-1:RSVD_BIT-HI_W], entry[ENT_W-1:BIG_W], lin[BIG_W-1:0]};
      end
    end
  end

  always_comb begin
    if (kind == EK_MAPPED && is_leaf)
      a_leaf_high_zero_r3: assert (pa[PA_W-1:LA_W] == '0);
  end
endmodule

// File: rtl/pw_addr_gen.sv
`timescale 1ns/1ps
module pw_addr_gen
  import pw_pkg::*;
(
  input  logic             second,
  input  logic [LA_W-1:0]  root,
  input  logic [ENT_W-1:0] ptr,
  input  logic [LA_W-1:0]  lin,
  output logic [LA_W-1:0]  addr
);
  logic unused_bits;
  assign unused_bits = ^{root[OFF_W-1:0], ptr[OFF_W-1:0]};

  always_comb begin
    if (second)
      addr = {ptr[ENT_W-1:OFF_W], lin[BIG_W-1:OFF_W], 2'b00};
    else
      addr = {root[LA_W-1:OFF_W], lin[LA_W-1:BIG_W], 2'b00};
  end
endmodule

// File: rtl/page_walker.sv
`timescale 1ns/1ps
module page_walker
  import pw_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [LA_W-1:0]     req_lin,
  input  logic [LA_W-1:0]     req_root,
  input  logic                req_large_en,
  output logic                mem_req,
  output logic [LA_W-1:0]     mem_addr,
  input  logic                mem_rvalid,
  input  logic [ENT_W-1:0]    mem_rdata,
  output logic                done,
  output logic                fault,
  output logic [PA_W-1:0]     phys_addr,
  output logic [1:0]          fault_level,
  output logic                fault_cause
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  walk_state_t state_q, state_d;
  logic [LA_W-1:0]  lin_q, root_q;
  logic             large_q;
  logic [ENT_W-1:0] ptr_q;
  logic [PA_W-1:0]  res_pa_q;
  logic             res_fault_q;
  logic [1:0]       res_lvl_q;
  fault_cause_t     res_cause_q;

  logic load_req, load_ptr, load_res;
  logic is_leaf;
  entry_kind_t  dec_kind;
  fault_cause_t dec_cause;
  logic [PA_W-1:0] dec_pa;

  assign is_leaf = (state_q == S_WT2);

  pw_entry_decode u_dec (
    .entry    (mem_rdata),
    .is_leaf  (is_leaf),
    .large_en (large_q),
    .lin      (lin_q),
    .kind     (dec_kind),
    .cause    (dec_cause),
    .pa       (dec_pa)
  );

  pw_addr_gen u_addr (
    .second (state_q == S_RD2),
    .root   (root_q),
    .ptr    (ptr_q),
    .lin    (lin_q),
    .addr   (mem_addr)
  );

  always_comb begin
    state_d  = state_q;
    load_req = 1'b0;
    load_ptr = 1'b0;
    load_res = 1'b0;
    case (state_q)
      S_IDLE: if (req_valid) begin
        state_d  = S_RD1;
        load_req = 1'b1;
      end
      S_RD1: state_d = S_WT1;
      S_WT1: if (mem_rvalid) begin
        if (dec_kind == EK_POINTER) begin
          state_d  = S_RD2;
          load_ptr = 1'b1;
        end else begin
          state_d  = S_RESP;
          load_res = 1'b1;
        end
      end
      S_RD2: state_d = S_WT2;
      S_WT2: if (mem_rvalid) begin
        state_d  = S_RESP;
        load_res = 1'b1;
      end
      S_RESP: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q     <= S_IDLE;
      lin_q       <= '0;
      root_q      <= '0;
      large_q     <= 1'b0;
      ptr_q       <= '0;
      res_pa_q    <= '0;
      res_fault_q <= 1'b0;
      res_lvl_q   <= 2'd0;
      res_cause_q <= FC_NOT_PRESENT;
    end else begin
      state_q <= state_d;
      if (load_req) begin
        lin_q   <= req_lin;
        root_q  <= req_root;
        large_q <= req_large_en;
      end
      if (load_ptr)
        ptr_q <= mem_rdata;
      if (load_res) begin
        res_fault_q <= (dec_kind == EK_FAULT);
        res_pa_q    <= (dec_kind == EK_FAULT) ? '0 : dec_pa;
        res_lvl_q   <= is_leaf ? 2'd2 : 2'd1;
        res_cause_q <= dec_cause;
      end
    end
  end

  assign req_ready   = (state_q == S_IDLE);
  assign mem_req     = (state_q == S_RD1) || (state_q == S_RD2);
  assign done        = (state_q == S_RESP) && !res_fault_q;
  assign fault       = (state_q == S_RESP) && res_fault_q;
  assign phys_addr   = res_pa_q;
  assign fault_level = res_lvl_q;
  assign fault_cause = res_cause_q;

  p_read_pulse_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_req |=> !mem_req);
  p_read_only_busy_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_req |-> !req_ready);
  p_accept_then_read_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    (req_ready && req_valid) |=> (mem_req && !req_ready));
  p_result_pulse_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (done || fault) |=> !(done || fault));
  p_fault_zero_pa_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    fault |-> (phys_addr == '0 && (fault_level == 2'd1 || fault_level == 2'd2)));
  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    !(done && fault));
  p_busy_result_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    (done || fault) |-> !req_ready);
endmodule

// File: tb/page_walker_test.sv
`timescale 1ns/1ps
module page_walker_test;
  localparam int CLK_NS = 10;
  localparam logic [31:0] ROOT = 32'h0010_0000;

  typedef struct packed {
    logic [31:0] lin;
    logic        lg;
    logic [31:0] pde;
    logic [31:0] pte;
    logic        flt;
    logic [1:0]  lvl;
    logic        cause;
    logic [39:0] pa;
    logic [1:0]  nrd;
    logic [1:0]  lat;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32'h0040_1234, 1'b1, 32'h0020_0001, 32'hABCD_E001, 1'b0, 2'd0, 1'b0, 40'h00_ABCD_E234, 2'd2, 2'd0}, // R3
    '{32'h0080_5678, 1'b1, 32'hC00B_4081, 32'h0000_0000, 1'b0, 2'd0, 1'b0, 40'h5A_C000_5678, 2'd1, 2'd2}, // R4
    '{32'h0080_5678, 1'b0, 32'hC00B_4081, 32'h1234_5003, 1'b0, 2'd0, 1'b0, 40'h00_1234_5678, 2'd2, 2'd1}, // R5
    '{32'h00C0_3ABC, 1'b1, 32'h0030_0001, 32'h0777_7081, 1'b0, 2'd0, 1'b0, 40'h00_0777_7ABC, 2'd2, 2'd3}, // R6
    '{32'h0100_0000, 1'b1, 32'h0040_0000, 32'h0000_0000, 1'b1, 2'd1, 1'b0, 40'h0,            2'd1, 2'd0}, // R7
    '{32'h0140_2000, 1'b0, 32'h0050_0001, 32'h0FFF_F0FE, 1'b1, 2'd2, 1'b0, 40'h0,            2'd2, 2'd1}, // R7 R9
    '{32'h0180_0000, 1'b1, 32'h0020_0081, 32'h0000_0000, 1'b1, 2'd1, 1'b1, 40'h0,            2'd1, 2'd2}, // R8
    '{32'h0180_0000, 1'b0, 32'h0020_0081, 32'h0008_8001, 1'b0, 2'd0, 1'b0, 40'h00_0008_8000, 2'd2, 2'd0}, // R8 R5
    '{32'h01C0_0000, 1'b1, 32'h0020_0080, 32'h0000_0000, 1'b1, 2'd1, 1'b0, 40'h0,            2'd1, 2'd1}  // R7
  };

  logic clk, rst_n;
  logic req_valid, req_ready, req_large_en;
  logic [31:0] req_lin, req_root;
  logic mem_req, mem_rvalid;
  logic [31:0] mem_addr, mem_rdata;
  logic done, fault, fault_cause;
  logic [39:0] phys_addr;
  logic [1:0] fault_level;

  page_walker uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_lin(req_lin), .req_root(req_root), .req_large_en(req_large_en),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .done(done), .fault(fault), .phys_addr(phys_addr),
    .fault_level(fault_level), .fault_cause(fault_cause)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  // memory model, driven away from the active edge
  logic [31:0] mem [logic [31:0]];
  logic [31:0] rd_addr [8];
  int rd_cnt = 0;
  int lat = 0;
  bit pend = 0;
  int cnt = 0;
  logic [31:0] pend_a;
  bit poke = 0;

  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
  end

  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (poke) begin
      mem_rvalid = 1'b1;
      mem_rdata  = 32'h0000_0001;
      poke = 0;
    end else if (pend) begin
      if (cnt == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = mem.exists(pend_a) ? mem[pend_a] : 32'h0;
        pend = 0;
      end else cnt--;
    end
    if (mem_req && rst_n) begin
      if (rd_cnt < 8) rd_addr[rd_cnt] = mem_addr;
      rd_cnt++;
      pend_a = mem_addr;
      cnt = lat;
      pend = 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_result(output bit got);
    got = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (done || fault) begin got = 1; break; end
    end
  endtask

  task automatic start(input logic [31:0] lin, input logic lg);
    @(negedge clk);
    req_valid = 1'b1; req_lin = lin; req_root = ROOT; req_large_en = lg;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [31:0] a1(input logic [31:0] lin);
    return {ROOT[31:12], lin[31:22], 2'b00};
  endfunction
  function automatic logic [31:0] a2(input logic [31:0] e, input logic [31:0] lin);
    return {e[31:12], lin[21:12], 2'b00};
  endfunction

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit got;
    int busy_cnt;
    rst_n = 1'b0; req_valid = 1'b0; req_lin = '0; req_root = '0; req_large_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    check(req_ready === 1'b1, "R11", "req_ready", 64'(req_ready), 64'd1);
    check(mem_req === 1'b0 && done === 1'b0 && fault === 1'b0, "R11", "req/done/fault",
          {61'd0, mem_req, done, fault}, 64'd0);
    check(phys_addr === 40'd0, "R11", "phys_addr", 64'(phys_addr), 64'd0);

    // R10 stray read data while idle
    poke = 1;
    repeat (3) @(negedge clk);
    check(rd_cnt == 0 && !done && !fault && req_ready, "R10", "stray rvalid",
          {rd_cnt[31:0], 29'd0, done, fault, req_ready}, {32'd0, 32'd1});

    // table-driven walks
    for (int v = 0; v < NV; v++) begin
      mem.delete();
      mem[a1(VECS[v].lin)] = VECS[v].pde;
      mem[a2(VECS[v].pde, VECS[v].lin)] = VECS[v].pte;
      lat = int'(VECS[v].lat);
      rd_cnt = 0;
      start(VECS[v].lin, VECS[v].lg);
      wait_result(got);
      check(got, "R3", $sformatf("v%0d result arrives", v), 64'(got), 64'd1);
      check(rd_cnt == int'(VECS[v].nrd), "R4", $sformatf("v%0d read count", v),
            64'(rd_cnt), 64'(VECS[v].nrd));
      check(rd_addr[0] == a1(VECS[v].lin), "R1", $sformatf("v%0d first addr", v),
            64'(rd_addr[0]), 64'(a1(VECS[v].lin)));
      if (VECS[v].nrd == 2'd2)
        check(rd_addr[1] == a2(VECS[v].pde, VECS[v].lin), "R2", $sformatf("v%0d second addr", v),
              64'(rd_addr[1]), 64'(a2(VECS[v].pde, VECS[v].lin)));
      check(fault === VECS[v].flt && done === !VECS[v].flt, "R9", $sformatf("v%0d done/fault", v),
            {62'd0, done, fault}, {62'd0, !VECS[v].flt, VECS[v].flt});
      check(phys_addr === VECS[v].pa, VECS[v].flt ? "R9" : "R3", $sformatf("v%0d phys_addr", v),
            64'(phys_addr), 64'(VECS[v].pa));
      if (VECS[v].flt)
        check(fault_level === VECS[v].lvl && fault_cause === VECS[v].cause,
              VECS[v].cause ? "R8" : "R7", $sformatf("v%0d level/cause", v),
              {61'd0, fault_level, fault_cause}, {61'd0, VECS[v].lvl, VECS[v].cause});
      @(negedge clk);
      check(!done && !fault && req_ready, "R3", $sformatf("v%0d single pulse", v),
            {61'd0, done, fault, req_ready}, 64'd1);
    end

    // R10 request held during a walk: result and next request meet
    mem.delete();
    mem[a1(VECS[0].lin)] = VECS[0].pde;
    mem[a2(VECS[0].pde, VECS[0].lin)] = VECS[0].pte;
    mem[a1(VECS[3].lin)] = VECS[3].pde;
    mem[a2(VECS[3].pde, VECS[3].lin)] = VECS[3].pte;
    lat = 1; rd_cnt = 0; busy_cnt = 0;
    @(negedge clk);
    req_valid = 1'b1; req_lin = VECS[0].lin; req_root = ROOT; req_large_en = 1'b1;
    @(negedge clk);
    req_lin = VECS[3].lin;
    got = 0;
    for (int i = 0; i < 100; i++) begin
      if (done || fault) begin got = 1; break; end
      if (!req_ready) busy_cnt++;
      @(negedge clk);
    end
    check(got && done && phys_addr === VECS[0].pa, "R10", "first result under held request",
          64'(phys_addr), 64'(VECS[0].pa));
    check(req_ready === 1'b0, "R10", "not ready in result cycle", 64'(req_ready), 64'd0);
    check(rd_cnt == 2, "R10", "no overlap reads", 64'(rd_cnt), 64'd2);
    @(negedge clk);
    check(req_ready === 1'b1, "R10", "ready after result", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    wait_result(got);
    check(got && done && phys_addr === VECS[3].pa, "R10", "second walk result",
          64'(phys_addr), 64'(VECS[3].pa));
    check(rd_cnt == 4 && rd_addr[2] == a1(VECS[3].lin), "R10", "second walk reads",
          64'(rd_cnt), 64'd4);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule